// File: doc/BRIEF.md
# Debug Probe Set/Clear Control Register with Sticky Sense Flags

This block is the control and status word of a debug probe. It holds the levels driven onto the target's system reset and test-logic reset lines, the target power switch, two indicator LEDs and the enable for adaptive (returned) clocking. Software never rewrites the whole word. A write to the SET offset turns on the bits that carry a 1, and a write to the CLEAR offset turns off the bits that carry a 1. Each software path can therefore change its own bit without a read-modify-write.

The same word also reports two sticky sense flags: system reset seen asserted, and target power dropout. Each raw sense input passes through a two-flop synchronizer. Once a flag is set, it stays set until software re-arms it. Software re-arms a flag by writing its bit to the SET offset. This loads the flag with the present synchronized level and discards the history. A later read of the SET offset reports whether the condition has appeared since that re-arm. The register bus is a plain single-cycle interface: address, write enable, write data, and combinational read data.

Top module: `probe_ctl_reg`

## Requirements
- R1: After reset all drive outputs are low, so power is on, and a read of offset 0x10 returns 0.
- R2: A write to offset 0x10 sets every control bit whose write-data bit is 1 and leaves all other control bits unchanged.
- R3: A write to offset 0x14 clears every control bit whose write-data bit is 1 and leaves all other control bits unchanged.
- R4: The control bits map to outputs as follows: bit 0 drives srstDrive, bit 1 drives trstDrive, bit 3 drives powerOff (1 means power off), bits 4 and 5 drive ledOn[0] and ledOn[1], and bit 8 drives adaptClkEn.
- R5: A read of offset 0x10 returns the control bits in their own positions, the system-reset flag at bit 6 and the power-dropout flag at bit 7. Every other bit reads 0, even after ones are written to it.
- R6: A read of offset 0x14, or of any other offset, returns 0. A write to an offset other than 0x10 or 0x14 changes nothing.
- R7: A sticky flag becomes 1 three clock edges after its sense input is sampled high, even when the input is high for only one cycle. It then stays 1 until it is re-armed.
- R8: A write to offset 0x10 with bit 6 (bit 7) set loads the system-reset (power-dropout) flag with the current synchronized sense level. This does not change any control bit.
- R9: A write to offset 0x14 with bit 6 or bit 7 set leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| srstSenseIn | input | 1 | Asynchronous level, target system reset seen low |
| powerDropIn | input | 1 | Asynchronous level, target power lost |
| srstDrive | output | 1 | Assert target system reset |
| trstDrive | output | 1 | Assert target test-logic reset |
| powerOff | output | 1 | Switch target power off |
| ledOn | output | 2 | Indicator LED enables |
| adaptClkEn | output | 1 | Enable adaptive returned-clock mode |

## Verification
A corrupted control bit appears on its drive pin and in the read word on the edge after the write that caused it. The bench sweeps every pattern of the six control bits through set and clear writes, so a wrong mask, a wrong bit position or a set/clear swap is caught at the next sample. A fault in a sticky flag shows at bit 6 or 7 of the read word. This includes a lost pulse, a flag that fails to hold, or a re-arm that fails to discard history. The bench checks these one cycle before and one cycle after the three-edge capture point, which also catches a synchronizer that is too short or too long.

// File: rtl/probe_ctl_pkg.sv
package probe_ctl_pkg;

  // Bit positions inside the register word
  localparam int unsigned BIT_SRST    = 0;
  localparam int unsigned BIT_TRST    = 1;
  localparam int unsigned BIT_PWROFF  = 3;
  localparam int unsigned BIT_LED0    = 4;
  localparam int unsigned BIT_LED1    = 5;
  localparam int unsigned BIT_FLAGRST = 6;
  localparam int unsigned BIT_FLAGPWR = 7;
  localparam int unsigned BIT_ADAPT   = 8;

  localparam int unsigned NUM_SENSE = 2;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic                 setStb;
    logic                 clrStb;
    logic [NUM_SENSE-1:0] rearm;    // [0] reset flag, [1] power flag
    logic                 readSel;
  } strobe_t;

endpackage

// File: rtl/probe_ctl_decode.sv
module probe_ctl_decode
  import probe_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb
);

  logic hitSet;
  logic hitClr;

  always_comb begin
    hitSet      = (busAddr == SET_OFS);
    hitClr      = (busAddr == CLR_OFS);
    stb.setStb  = busWe && hitSet;
    stb.clrStb  = busWe && hitClr;
    stb.rearm   = {busWdata[BIT_FLAGPWR], busWdata[BIT_FLAGRST]} & {NUM_SENSE{stb.setStb}};
    stb.readSel = hitSet;
  end

  // The two write paths never fire together (R2, R3)
  assert_one_write_path_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setStb, stb.clrStb}));

  // A re-arm only comes from a write to the SET offset (R9)
  assert_rearm_only_on_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rearm != '0) |-> (busWe && busAddr == SET_OFS));

endmodule

// File: rtl/probe_ctl_datapath.sv
module probe_ctl_datapath
  import probe_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_SENSE-1:0] senseRaw,
  output logic [DATA_W-1:0]    ctrlQ,
  output logic [DATA_W-1:0]    rdata
);

  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << BIT_SRST) | (1 << BIT_TRST) | (1 << BIT_PWROFF) |
            (1 << BIT_LED0) | (1 << BIT_LED1) | (1 << BIT_ADAPT));

  logic [DATA_W-1:0]    wMasked;
  logic [NUM_SENSE-1:0] senseSync;
  logic [NUM_SENSE-1:0] flagQ;

  assign wMasked = busWdata & CTRL_MASK;

  // Control word: set and clear paths
  always_ff @(posedge clk) begin
    if (!rstN)           ctrlQ <= '0;
    else if (stb.setStb) ctrlQ <= ctrlQ | wMasked;
    else if (stb.clrStb) ctrlQ <= ctrlQ & ~wMasked;
  end

  // One synchronizer and one sticky flag per sense input
  for (genvar k = 0; k < NUM_SENSE; k++) begin : gSense
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], senseRaw[k]};
    end
    assign senseSync[k] = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rstN)             flagQ[k] <= 1'b0;
      else if (stb.rearm[k]) flagQ[k] <= senseSync[k];
      else                   flagQ[k] <= flagQ[k] | senseSync[k];
    end

    // A set flag holds until re-armed (R7)
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[k] && !stb.rearm[k]) |=> flagQ[k]);

    // A synchronized high level is always captured (R7)
    assert_flag_captures_R7: assert property (@(posedge clk) disable iff (!rstN)
      senseSync[k] |=> flagQ[k]);

    // A re-arm loads the present synchronized level (R8)
    assert_rearm_loads_R8: assert property (@(posedge clk) disable iff (!rstN)
      stb.rearm[k] |=> (flagQ[k] == $past(senseSync[k])));
  end

  // Read mux: only the SET offset returns data
  always_comb begin
    rdata = '0;
    if (stb.readSel) begin
      rdata              = ctrlQ;
      rdata[BIT_FLAGRST] = flagQ[0];
      rdata[BIT_FLAGPWR] = flagQ[1];
    end
  end

  // Set path turns on exactly the written bits (R2)
  assert_set_bits_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setStb |=> ((ctrlQ & $past(wMasked)) == $past(wMasked)));

  // Clear path turns off the written bits (R3)
  assert_clr_bits_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |=> ((ctrlQ & $past(wMasked)) == '0));

  // Without a write the control word is stable (R6)
  assert_ctrl_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setStb || stb.clrStb) |=> $stable(ctrlQ));

  // Bits outside the control mask never appear in the control word (R5)
  assert_ctrl_in_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ & ~CTRL_MASK) == '0);

endmodule

// File: rtl/probe_ctl_reg.sv
module probe_ctl_reg
  import probe_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              srstSenseIn,
  input  logic              powerDropIn,
  output logic              srstDrive,
  output logic              trstDrive,
  output logic              powerOff,
  output logic [1:0]        ledOn,
  output logic              adaptClkEn
);

  strobe_t           stb;
  logic [DATA_W-1:0] ctrlQ;

  probe_ctl_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) uDecode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .stb(stb)
  );

  probe_ctl_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .senseRaw({powerDropIn, srstSenseIn}), .ctrlQ(ctrlQ), .rdata(busRdata)
  );

  assign srstDrive  = ctrlQ[BIT_SRST];
  assign trstDrive  = ctrlQ[BIT_TRST];
  assign powerOff   = ctrlQ[BIT_PWROFF];
  assign ledOn      = {ctrlQ[BIT_LED1], ctrlQ[BIT_LED0]};
  assign adaptClkEn = ctrlQ[BIT_ADAPT];

endmodule

// File: tb/sim_probe_ctl_reg.sv
module sim_probe_ctl_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        srstSenseIn = 1'b0;
  logic        powerDropIn = 1'b0;
  logic        srstDrive, trstDrive, powerOff, adaptClkEn;
  logic [1:0]  ledOn;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expCtrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  probe_ctl_reg u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .srstSenseIn(srstSenseIn),
    .powerDropIn(powerDropIn), .srstDrive(srstDrive), .trstDrive(trstDrive),
    .powerOff(powerOff), .ledOn(ledOn), .adaptClkEn(adaptClkEn)
  );

  // Spread a 6-bit pattern onto control positions 0,1,3,4,5,8
  function automatic logic [31:0] spread(input logic [5:0] p);
    logic [31:0] w = '0;
    w[0] = p[0]; w[1] = p[1]; w[3] = p[2];
    w[4] = p[3]; w[5] = p[4]; w[8] = p[5];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic checkPins(input string req);
    logic [31:0] pins = '0;
    pins[0] = srstDrive; pins[1] = trstDrive; pins[3] = powerOff;
    pins[4] = ledOn[0]; pins[5] = ledOn[1]; pins[8] = adaptClkEn;
    check(req, pins, expCtrl);
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkPins("R1 pins after reset");
    busRead(8'h10, rd); check("R1 read after reset", rd, 32'h0);

    // R2/R3/R4/R5: sweep all control patterns
    for (int p = 0; p < 64; p++) begin
      busWrite(8'h14, 32'hFFFF_FF3F);
      expCtrl = '0;
      busWrite(8'h10, spread(6'(p)) | 32'hFFFF_FE04);
      expCtrl = spread(6'(p));
      checkPins("R4 pins after set");
      busRead(8'h10, rd); check("R2 R5 readback after set", rd, expCtrl);
      begin
        logic [5:0] c = 6'(p ^ (p >> 1)) ^ 6'h15;
        busWrite(8'h14, spread(c));
        expCtrl = expCtrl & ~spread(c);
        checkPins("R3 pins after clear");
        busRead(8'h10, rd); check("R3 readback after clear", rd, expCtrl);
      end
      begin
        logic [5:0] s = 6'(p * 7);
        busWrite(8'h10, spread(s));
        expCtrl = expCtrl | spread(s);
        busRead(8'h10, rd); check("R2 set preserves others", rd, expCtrl);
      end
    end

    // R6: other offsets
    busWrite(8'h18, 32'hFFFF_FFFF);
    busWrite(8'h00, 32'h0);
    checkPins("R6 write elsewhere ignored");
    busRead(8'h14, rd); check("R6 read of clear offset", rd, 32'h0);
    busRead(8'h18, rd); check("R6 read of other offset", rd, 32'h0);
    busRead(8'h10, rd); check("R6 word unchanged", rd, expCtrl);

    // R7: single-cycle pulse on reset sense, capture at third edge
    busWrite(8'h14, 32'h13B); expCtrl = '0;
    busWrite(8'h10, 32'hC0);
    busRead(8'h10, rd); check("R8 re-armed low", rd, 32'h0);
    srstSenseIn = 1'b1;
    @(negedge clk); srstSenseIn = 1'b0;
    waitEdges(1);
    busRead(8'h10, rd); check("R7 not yet after two edges", rd, 32'h0);
    waitEdges(1);
    busRead(8'h10, rd); check("R7 captured after three edges", rd, 32'h40);
    waitEdges(10);
    busRead(8'h10, rd); check("R7 flag holds", rd, 32'h40);

    // R9: clear offset does not touch flags
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h10, rd); check("R9 clear ignores flag", rd, 32'h40);

    // R8: re-arm discards history, keeps control bits
    busWrite(8'h10, 32'h30); expCtrl = 32'h30;
    busWrite(8'h10, 32'h40);
    busRead(8'h10, rd); check("R8 re-arm clears history", rd, 32'h30);
    checkPins("R8 re-arm keeps control bits");

    // R7/R8: power dropout flag, held level, re-arm while high
    powerDropIn = 1'b1;
    waitEdges(3);
    busRead(8'h10, rd); check("R7 power flag captured", rd, 32'hB0);
    busWrite(8'h10, 32'h80);
    busRead(8'h10, rd); check("R8 re-arm while high", rd, 32'hB0);
    powerDropIn = 1'b0;
    waitEdges(3);
    busRead(8'h10, rd); check("R7 power flag held after drop", rd, 32'hB0);
    busWrite(8'h14, 32'h80);
    busRead(8'h10, rd); check("R9 clear ignores power flag", rd, 32'hB0);
    busWrite(8'h10, 32'h80);
    busRead(8'h10, rd); check("R8 power re-arm low", rd, 32'h30);

    // R1: reset again mid-run
    srstSenseIn = 1'b1;
    waitEdges(4);
    rstN = 1'b0; waitEdges(1); rstN = 1'b1; srstSenseIn = 1'b0;
    expCtrl = '0;
    busRead(8'h10, rd); check("R1 second reset", rd, 32'h0);
    checkPins("R1 pins after second reset");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule